// File: doc/BRIEF.md
# Poll-Started Mean-Square Power Estimator

This block estimates the power of a zero-mean fluctuation signal for a wide-range flux channel. It averages the squares of signed converter samples. A poll strobe from the supervising processor starts a capture. Each sample that arrives with its valid strobe is squared in a registered multiplier and added to a wide accumulator. When the fixed sample count is reached, the sum is shifted right to form the mean, the mean is written to a held output register, the done flag rises and the block returns to idle until the next poll.

The band-pass filtering ahead of the block removes the DC component, so the mean square is used directly as the variance estimate. A capture has a fixed cycle budget, counted from the poll. If the samples come too slowly to fill the window within that budget, the capture is abandoned and a timeout flag is latched instead of the done flag. Defaults: 12-bit two's-complement samples, 1024 samples per estimate (a 10-bit shift), a 34-bit accumulator and a window of 78125 cycles (1/256 s at 20 MHz).

Top module: `msq_power_est`

## Requirements
- R1: After reset, `result_o` is 0 and `done_o` and `timeout_o` are both low.
- R2: A capture starts only on a clock edge where `poll_i` is high and the block is idle. Valid samples seen while idle have no effect. `done_o` and `timeout_o` are low from the edge that starts a capture.
- R3: `result_o` equals the sum of the squares of the accepted samples, shifted right by 10 bits (floor of the mean over 1024 samples). `smp_data_i` is read as 12-bit two's complement.
- R4: Only cycles with `smp_valid_i` high contribute a sample, and any gap pattern between them gives the same result.
- R5: With the registered square, `done_o` rises and `result_o` takes its new value on the second clock edge after the edge that accepts the 1024th sample.
- R6: Once a capture has completed, `result_o` and `done_o` hold their values while idle, whatever the sample inputs do, until the next poll.
- R7: A poll in any cycle where the block is not idle is ignored. This includes the drain and write cycles, and it neither restarts nor changes the capture.
- R8: Samples that arrive after the 1024th accepted sample and before the next capture do not change the result.
- R9: If fewer than 1024 samples have been accepted by the 78125th edge after the poll edge, `timeout_o` is set on that edge. `done_o` stays low, `result_o` keeps its previous value, and `timeout_o` clears on the next capture start.
- R10: A 1024th sample accepted on the last edge of the window completes normally. One edge later, the capture times out instead.
- R11: Full-scale inputs do not overflow: all -2048 gives 4194304, and all +2047 gives 4190209.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_i | input | 1 | Processor poll; starts a capture when idle |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | SAMPLE_W (12) | Signed sample, two's complement |
| result_o | output | 2*SAMPLE_W (24) | Mean of the squares of the last completed capture |
| done_o | output | 1 | Last capture completed; cleared on the next start |
| timeout_o | output | 1 | Last capture ran out of its cycle window |

## Verification
The hardest condition to reach is the window edge itself: the 1024th sample landing exactly on the last counted edge, and the capture that misses it by one edge. At the default window this needs tens of thousands of idle cycles. The bench therefore shrinks the window parameter and drives a computed number of idle cycles after the poll, so that the final sample falls on the last edge in one run and one edge later in the next. Polls that arrive during a capture, and samples that arrive during the drain cycles, are injected at random inside the sample stream. A reference model run every cycle shows that neither changes the outcome.

// File: rtl/msq_pkg.sv
package msq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } msq_state_e;

endpackage

// File: rtl/msq_square.sv
module msq_square #(
   parameter int SAMPLE_W = 12,
   parameter bit MUL_REG  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take_i,
   input  logic [SAMPLE_W-1:0]     data_i,
   output logic                    sq_vld_o,
   output logic [2*SAMPLE_W-1:0]   sq_o
);
   localparam int SQ_W = 2 * SAMPLE_W;

   logic signed [SQ_W-1:0] ext;
   logic signed [SQ_W-1:0] prod;
   logic        [SQ_W-1:0] sq_mag;

   // sign-extend to full width so the product is exact
   assign ext    = {{SAMPLE_W{data_i[SAMPLE_W-1]}}, data_i};
   assign prod   = ext * ext;
   assign sq_mag = prod;

   generate
      if (MUL_REG) begin : g_reg
         logic            vld_q;
         logic [SQ_W-1:0] sq_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               sq_q  <= '0;
            end else begin
               vld_q <= take_i;
               if (take_i) sq_q <= sq_mag;
            end
         end

         assign sq_vld_o = vld_q;
         assign sq_o     = sq_q;

         // R5: one cycle of multiplier latency
         p_sq_latency_r5 : assert property (@(posedge clk) disable iff (!rst_n)
            take_i |=> sq_vld_o);
      end else begin : g_comb
         assign sq_vld_o = take_i;
         assign sq_o     = sq_mag;
      end
   endgenerate

endmodule

// File: rtl/msq_accum.sv
module msq_accum #(
   parameter int SQ_W   = 24,
   parameter int N_LOG2 = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            sq_vld_i,
   input  logic [SQ_W-1:0] sq_i,
   input  logic            wr_i,
   output logic [SQ_W-1:0] result_o
);
   localparam int ACC_W = SQ_W + N_LOG2;
   localparam logic [SQ_W-1:0] MAX_MEAN = SQ_W'(1) << (SQ_W - 2);

   logic [ACC_W-1:0] acc_q;
   logic [SQ_W-1:0]  res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr_i) begin
         acc_q <= '0;
      end else if (sq_vld_i) begin
         acc_q <= acc_q + {{N_LOG2{1'b0}}, sq_i};
      end
   end

   // the mean is a plain right shift by the window exponent
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (wr_i) begin
         res_q <= acc_q[ACC_W-1:N_LOG2];
      end
   end

   assign result_o = res_q;

   // R6: the output register moves only on a write
   p_result_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(result_o));

   // R11: the mean of squares never exceeds the full-scale square
   p_mean_bound_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      result_o <= MAX_MEAN);

endmodule

// File: rtl/msq_ctrl.sv
module msq_ctrl
   import msq_pkg::*;
#(
   parameter int N_LOG2        = 10,
   parameter int WINDOW_CYCLES = 78125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic poll_i,
   input  logic valid_i,
   input  logic sq_vld_i,
   output logic take_o,
   output logic clr_o,
   output logic wr_o,
   output logic done_o,
   output logic timeout_o
);
   localparam int NUM   = 1 << N_LOG2;
   localparam int CNT_W = N_LOG2 + 1;
   localparam int CYC_W = $clog2(WINDOW_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM);
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(WINDOW_CYCLES - 1);
   localparam logic [CYC_W-1:0] CYC_LIM  = CYC_W'(WINDOW_CYCLES);

   msq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CYC_W-1:0] cyc_q;
   logic             done_q, tmo_q;
   logic             last_smp, win_end;

   assign take_o   = (state_q == ST_RUN) && valid_i;
   assign clr_o    = (state_q == ST_IDLE) && poll_i;
   assign wr_o     = (state_q == ST_DRAIN) && !sq_vld_i;
   assign last_smp = take_o && (cnt_q == CNT_LAST);
   assign win_end  = (cyc_q == CYC_LAST);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (poll_i) state_d = ST_RUN;
         ST_RUN:   if (last_smp) state_d = ST_DRAIN;
                   else if (win_end) state_d = ST_IDLE;
         ST_DRAIN: if (!sq_vld_i) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         cyc_q   <= '0;
         done_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (clr_o) begin
            cnt_q  <= '0;
            cyc_q  <= '0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
         end else begin
            if (take_o) cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_RUN) cyc_q <= cyc_q + 1'b1;
            if (wr_o) done_q <= 1'b1;
            if ((state_q == ST_RUN) && !last_smp && win_end) tmo_q <= 1'b1;
         end
      end
   end

   assign done_o    = done_q;
   assign timeout_o = tmo_q;

   // R2: a start clears both completion flags on the next cycle
   p_start_clears_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && poll_i) |=> (!done_o && !timeout_o && state_q == ST_RUN));

   // R7: a running window is never restarted
   p_no_restart_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && state_d == ST_RUN) |=> (cyc_q == CYC_W'($past(cyc_q) + 1'b1)));

   // R8: never more than the window of samples is taken
   p_cnt_bound_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   // R9: the cycle counter stays inside the window while running
   p_window_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (cyc_q < CYC_LIM));

endmodule

// File: rtl/msq_power_est.sv
module msq_power_est #(
   parameter int SAMPLE_W      = 12,
   parameter int N_LOG2        = 10,
   parameter int WINDOW_CYCLES = 78125,
   parameter bit MUL_REG       = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  poll_i,
   input  logic                  smp_valid_i,
   input  logic [SAMPLE_W-1:0]   smp_data_i,
   output logic [2*SAMPLE_W-1:0] result_o,
   output logic                  done_o,
   output logic                  timeout_o
);
   localparam int SQ_W = 2 * SAMPLE_W;

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
      if (N_LOG2 < 1 || N_LOG2 > 20) begin : g_bad_depth
         $error("N_LOG2 must lie in 1..20");
      end
      if (WINDOW_CYCLES < (1 << N_LOG2)) begin : g_bad_window
         $error("WINDOW_CYCLES must cover at least one sample per cycle");
      end
   endgenerate

   logic            take, clr, wr, sq_vld;
   logic [SQ_W-1:0] sq;

   msq_ctrl #(
      .N_LOG2        (N_LOG2),
      .WINDOW_CYCLES (WINDOW_CYCLES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .poll_i    (poll_i),
      .valid_i   (smp_valid_i),
      .sq_vld_i  (sq_vld),
      .take_o    (take),
      .clr_o     (clr),
      .wr_o      (wr),
      .done_o    (done_o),
      .timeout_o (timeout_o)
   );

   msq_square #(
      .SAMPLE_W (SAMPLE_W),
      .MUL_REG  (MUL_REG)
   ) u_square (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (take),
      .data_i   (smp_data_i),
      .sq_vld_o (sq_vld),
      .sq_o     (sq)
   );

   msq_accum #(
      .SQ_W   (SQ_W),
      .N_LOG2 (N_LOG2)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .sq_vld_i (sq_vld),
      .sq_i     (sq),
      .wr_i     (wr),
      .result_o (result_o)
   );

   // R9: completion and timeout never coexist
   p_done_tmo_excl_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && timeout_o));

   // R1: flags are low in the first cycle out of reset
   p_reset_flags_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!done_o && !timeout_o));

endmodule

// File: tb/msq_power_est_tb_top.sv
module msq_power_est_tb_top;
   localparam int CLK_PERIOD = 50;
   localparam int TB_WIN     = 2000;
   localparam int NSMP       = 1024;
   localparam int LAT        = 1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        poll;
   logic        vld;
   logic [11:0] data;
   logic [23:0] result;
   logic        done;
   logic        tmo;

   int nchecks = 0;
   int nerr    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msq_power_est #(
      .SAMPLE_W      (12),
      .N_LOG2        (10),
      .WINDOW_CYCLES (TB_WIN),
      .MUL_REG       (1'b1)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .poll_i      (poll),
      .smp_valid_i (vld),
      .smp_data_i  (data),
      .result_o    (result),
      .done_o      (done),
      .timeout_o   (tmo)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      nchecks++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference: phase 0 idle, 1 collecting, 2 draining
   int     m_phase, m_cnt, m_cyc, m_wait;
   longint m_sum, m_res;
   bit     m_done, m_tmo;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_cyc = 0; m_wait = 0;
         m_sum = 0; m_res = 0; m_done = 0; m_tmo = 0;
      end else begin
         case (m_phase)
            0: if (poll) begin
                  m_phase = 1; m_cnt = 0; m_sum = 0; m_cyc = 0;
                  m_done = 0; m_tmo = 0;
               end
            1: begin
                  bit fin;
                  fin = 0;
                  if (vld) begin
                     longint v;
                     v = longint'($signed(data));
                     m_sum += v * v;
                     m_cnt++;
                     if (m_cnt == NSMP) fin = 1;
                  end
                  if (fin) begin
                     m_phase = 2; m_wait = LAT;
                  end else if (m_cyc == TB_WIN - 1) begin
                     m_phase = 0; m_tmo = 1;
                  end
                  m_cyc++;
               end
            default: if (m_wait == 0) begin
                  m_res = m_sum >>> 10; m_done = 1; m_phase = 0;
               end else m_wait--;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 model result", result, m_res);
         chk("R5 model done", done, m_done);
         chk("R9 model timeout", tmo, m_tmo);
      end
   end

   task automatic poll_pulse();
      @(negedge clk); poll = 1'b1;
      @(negedge clk); poll = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         vld = 1'b0; @(negedge clk);
      end
   endtask

   // mode 0 random, 1 all -2048, 2 all +2047
   task automatic feed(input int n, input int gap_pct, input int mode,
                       input bit noise, output longint ssum);
      ssum = 0;
      for (int i = 0; i < n; i++) begin
         while ($urandom_range(0, 99) < gap_pct) begin
            vld  = 1'b0;
            poll = noise && ($urandom_range(0, 3) == 0);
            @(negedge clk);
         end
         begin
            logic [11:0] d;
            longint v;
            d = (mode == 1) ? 12'h800 : (mode == 2) ? 12'h7FF : 12'($urandom);
            v = longint'($signed(d));
            ssum += v * v;
            vld  = 1'b1;
            data = d;
            poll = noise && ($urandom_range(0, 3) == 0);
         end
         @(negedge clk);
      end
      vld  = 1'b0;
      poll = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20 && !done; i++) @(negedge clk);
   endtask

   initial begin
      longint s;
      longint keep;
      rst_n = 1'b0; poll = 1'b0; vld = 1'b0; data = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 result", result, 0);
      chk("R1 done", done, 0);
      chk("R1 timeout", tmo, 0);

      // R2: samples while idle have no effect
      for (int i = 0; i < 20; i++) begin
         vld = 1'b1; data = 12'($urandom); @(negedge clk);
      end
      vld = 1'b0;
      @(negedge clk);
      chk("R2 idle result", result, 0);
      chk("R2 idle done", done, 0);

      // R3/R5: dense random capture and completion latency
      poll_pulse();
      feed(NSMP, 0, 0, 1'b0, s);
      chk("R5 done after accept edge", done, 0);
      @(negedge clk);
      chk("R5 done after +1 edge", done, 0);
      @(negedge clk);
      chk("R5 done after +2 edge", done, 1);
      chk("R3 mean of squares", result, s >>> 10);
      keep = s >>> 10;

      // R6: hold while idle under sample activity
      for (int i = 0; i < 40; i++) begin
         vld = 1'b1; data = 12'($urandom); @(negedge clk);
      end
      vld = 1'b0;
      chk("R6 result held", result, keep);
      chk("R6 done held", done, 1);

      // R2/R4/R7/R8: gaps, busy polls, late samples
      poll_pulse();
      chk("R2 done cleared on start", done, 0);
      feed(NSMP, 40, 0, 1'b1, s);
      vld = 1'b1; data = 12'h7FF; poll = 1'b1; @(negedge clk);
      vld = 1'b1; data = 12'h800; @(negedge clk);
      vld = 1'b0; poll = 1'b0;
      wait_done();
      chk("R4 gapped mean", result, s >>> 10);
      chk("R7 busy polls ignored done", done, 1);
      @(negedge clk);
      chk("R8 late samples ignored", result, s >>> 10);

      // R11: full scale
      poll_pulse();
      feed(NSMP, 10, 1, 1'b0, s);
      wait_done();
      chk("R11 all -2048", result, 4194304);
      poll_pulse();
      feed(NSMP, 0, 2, 1'b0, s);
      wait_done();
      chk("R11 all +2047", result, 4190209);

      // R9: too few samples in the window
      poll_pulse();
      feed(500, 0, 0, 1'b0, s);
      idle(TB_WIN - 1 - 500);
      chk("R9 no timeout before window end", tmo, 0);
      @(negedge clk);
      chk("R9 timeout at window end", tmo, 1);
      chk("R9 done low on timeout", done, 0);
      chk("R9 result kept", result, 4190209);

      // R10: last sample exactly on the final edge
      poll_pulse();
      chk("R9 timeout cleared on start", tmo, 0);
      idle(TB_WIN - NSMP);
      feed(NSMP, 0, 0, 1'b0, s);
      wait_done();
      chk("R10 on-edge completes", done, 1);
      chk("R10 on-edge timeout low", tmo, 0);
      chk("R10 on-edge mean", result, s >>> 10);
      keep = s >>> 10;

      // R10: one edge late
      poll_pulse();
      idle(TB_WIN - NSMP + 1);
      feed(NSMP, 0, 0, 1'b0, s);
      repeat (3) @(negedge clk);
      chk("R10 late timeout", tmo, 1);
      chk("R10 late done low", done, 0);
      chk("R10 late result kept", result, keep);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      nchecks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end

endmodule